// File: doc/BRIEF.md
# Serial Configuration Write Receiver

This block is a write-only two-wire serial slave that sits beside a ten-output clock fan-out buffer. It samples the serial clock and data lines with a fast system clock and detects START and STOP conditions. It shifts in bytes MSB first and acknowledges them by pulling the open-drain data line low. A fixed eleven-byte write frame is expected: a device address, two filler bytes whose values are ignored, and eight data bytes. Only the last three data bytes are kept.

The kept bytes hold a per-output enable mask and one spare byte that can be observed for debug. Each clock output is driven only when the external output-enable pin is high and that output's mask bit is set. All mask bits come up set after reset, so every output runs as soon as the pin allows it. A frame whose address does not match changes nothing.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset every enable bit and every bit of `dbg_byte` is 1, and `sda_pull` is 0.
- R2: The first byte after a START is acknowledged only if it equals 8'hD2. Any other value gets no acknowledge on any byte of that frame, and no register changes.
- R3: Frame bytes 2 and 3 are acknowledged on a matched frame and their values have no effect on any output.
- R4: Frame bytes 4 to 8 (data bytes 0 to 4) are acknowledged on a matched frame and their values have no effect on any output.
- R5: Bits shift in MSB first. Frame byte 9 loads enable bits [7:0]. Bits [1:0] of frame byte 10 load enable bits [9:8]. Frame byte 11 loads `dbg_byte`.
- R6: A kept byte is committed on the SCL fall that starts its acknowledge clock. A STOP in the middle of a frame keeps the bytes already committed and restarts the byte count.
- R7: `out_en[i]` is 1 only when `oe_pin` is 1 and enable bit i is 1, and `clk_out[i]` equals `buf_in` gated by `out_en[i]`.
- R8: Bytes after the eleventh are not acknowledged and change nothing.
- R9: A repeated START in the middle of a frame restarts the frame at the address byte.
- R10: `sda_pull` is asserted only during the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_pull | output | 1 | Pulls the data line low for an acknowledge |
| oe_pin | input | 1 | Global output enable |
| buf_in | input | 1 | Clock to be fanned out |
| out_en | output | NUM_OUT | Per-output drive enable (0 means high impedance) |
| clk_out | output | NUM_OUT | Gated copies of `buf_in` |
| dbg_byte | output | 8 | Last committed value of frame byte 11 |

## Verification
The assertions check several rules on every cycle. Acknowledge drive appears only in the acknowledge clock, only on a matched frame, and only within eleven bytes. Kept registers change only right after an SCL fall. Outputs stay off with the pin low, and `clk_out` never runs on a disabled output. Which byte lands in which field, and whether filler bytes are really ignored, can only be shown by the bench's frames. The same holds for partial frames cut by STOP or a repeated START, and for bytes past the end of the frame.

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int          NUM_OUT    = 10,
  parameter logic [7:0]  DEV_ADDR   = 8'hD2,
  parameter int          FRAME_LEN  = 11,
  parameter int          FIRST_KEEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic               oe_pin,
  input  logic               buf_in,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [7:0]         dbg_byte
);
  localparam int KEEP_BYTES = FRAME_LEN - FIRST_KEEP;
  localparam int CW = 8 * KEEP_BYTES;
  localparam int IW = $clog2(FRAME_LEN + 1);
  localparam logic [IW-1:0] LEN_I  = IW'(FRAME_LEN);
  localparam logic [IW-1:0] KEEP_I = IW'(FIRST_KEEP);

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic busy, matched, ack;
  logic [3:0] bit_cnt;
  logic [IW-1:0] byte_idx;
  logic [7:0] shreg;
  logic [CW-1:0] ctl;

  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire byte_end = busy & scl_fall & (bit_cnt == 4'd8);
  wire commit   = byte_end & ~start & ~stop & matched & (byte_idx >= KEEP_I) & (byte_idx < LEN_I);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= '1;
      busy     <= 1'b0;
      matched  <= 1'b0;
      ack      <= 1'b0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      ctl      <= '1;
    end else begin
      scl_m <= scl_in;  scl_s <= scl_m;  scl_q <= scl_s;
      sda_m <= sda_in;  sda_s <= sda_m;  sda_q <= sda_s;
      if (start) begin
        busy     <= 1'b1;
        matched  <= 1'b0;
        ack      <= 1'b0;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (stop) begin
        busy     <= 1'b0;
        ack      <= 1'b0;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (busy) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (byte_end) begin
          bit_cnt <= 4'd9;
          if (byte_idx == '0) begin
            matched <= (shreg == DEV_ADDR);
            ack     <= (shreg == DEV_ADDR);
          end else begin
            ack <= matched && (byte_idx < LEN_I);
          end
          for (int k = 0; k < KEEP_BYTES; k++)
            if (commit && byte_idx == KEEP_I + IW'(k))
              ctl[k*8 +: 8] <= shreg;
        end else if (scl_fall && bit_cnt == 4'd9) begin
          ack     <= 1'b0;
          bit_cnt <= '0;
          if (byte_idx != LEN_I) byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  assign sda_pull = ack;
  assign out_en   = {NUM_OUT{oe_pin}} & ctl[NUM_OUT-1:0];
  assign clk_out  = out_en & {NUM_OUT{buf_in}};
  assign dbg_byte = ctl[CW-1 -: 8];
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int NUM_OUT   = 10,
  parameter int FRAME_LEN = 11,
  parameter int IW        = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oe_pin,
  input logic [NUM_OUT-1:0] out_en,
  input logic [NUM_OUT-1:0] clk_out,
  input logic [7:0]         dbg_byte,
  input logic               sda_pull,
  input logic               scl_s,
  input logic               scl_q,
  input logic               matched,
  input logic [3:0]         bit_cnt,
  input logic [IW-1:0]      byte_idx
);
  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (dbg_byte == 8'hFF) && !sda_pull);

  a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> matched);

  a_r10_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (bit_cnt == 4'd9));

  a_r8_no_ack_past_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (int'(byte_idx) < FRAME_LEN));

  a_r6_dbg_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_byte) |-> ($past(scl_q) && !$past(scl_s)));

  a_r6_en_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(oe_pin) && !$stable(out_en)) |-> ($past(scl_q) && !$past(scl_s)));

  a_r7_oe_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_pin |-> (out_en == '0));

  a_r7_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~out_en) == '0);
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.NUM_OUT(NUM_OUT), .FRAME_LEN(FRAME_LEN), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .out_en(out_en), .clk_out(clk_out),
  .dbg_byte(dbg_byte), .sda_pull(sda_pull), .scl_s(scl_s), .scl_q(scl_q),
  .matched(matched), .bit_cnt(bit_cnt), .byte_idx(byte_idx)
);

// File: tb/cfg_serial_rx_bench.sv
module cfg_serial_rx_bench;
  localparam int CLK_P = 10;
  localparam logic [7:0] ADDR = 8'hD2;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, oe = 1, buf_in = 0;
  logic sda_pull;
  logic [9:0] out_en, clk_out;
  logic [7:0] dbg_byte;
  wire sda_line = sda_m & ~sda_pull;

  cfg_serial_rx u_cfg_serial_rx (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .oe_pin(oe), .buf_in(buf_in), .out_en(out_en), .clk_out(clk_out), .dbg_byte(dbg_byte)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, quiet = 0;
  logic [9:0] exp_en = '1;
  logic [7:0] exp_dbg = 8'hFF;
  int m_idx = 0;
  logic m_match = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin @(posedge clk); #1 buf_in = ~buf_in; end
  end

  // per-clock comparison against the model (R5, R7)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (quiet > 0) begin quiet--; continue; end
      chk(out_en == ({10{oe}} & exp_en), "R7 R5 out_en", 16'(out_en), 16'({10{oe}} & exp_en));
      chk(clk_out == (out_en & {10{buf_in}}), "R7 clk_out", 16'(clk_out), 16'(out_en & {10{buf_in}}));
      chk(dbg_byte == exp_dbg, "R5 dbg_byte", 16'(dbg_byte), 16'(exp_dbg));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic half(); repeat (8) @(posedge clk); #1; endtask
  task automatic gap();  repeat (2) @(posedge clk); #1; endtask

  task automatic i2c_start();
    sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; quiet = 6; gap();
    m_idx = 0; m_match = 0;
  endtask

  task automatic i2c_stop();
    sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half();
    m_idx = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    logic exp_ack;
    exp_ack = (m_idx == 0) ? (b == ADDR) : (m_match && m_idx < 11);
    if (m_idx == 0) m_match = (b == ADDR);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1; half(); scl_m = 0; quiet = 6; gap();
    end
    if (m_match && m_idx == 8)  exp_en[7:0] = b;
    if (m_match && m_idx == 9)  exp_en[9:8] = b[1:0];
    if (m_match && m_idx == 10) exp_dbg = b;
    sda_m = 1; half(); scl_m = 1;
    repeat (4) @(negedge clk);
    chk(!sda_line == exp_ack, tag, 16'(!sda_line), 16'(exp_ack));
    repeat (4) @(posedge clk); #1;
    scl_m = 0; quiet = 6; gap();
    if (m_idx < 11) m_idx++;
  endtask

  function automatic string tag_of(input int idx);
    if (idx == 0) return "R2 address ack";
    if (idx < 3)  return "R3 filler ack";
    if (idx < 8)  return "R4 discarded ack";
    if (idx < 11) return "R5 kept ack";
    return "R8 extra byte nack";
  endfunction

  task automatic send_frame(input logic [7:0] a, input logic [7:0] d5, input logic [7:0] d6,
                            input logic [7:0] d7, input logic [7:0] fill);
    i2c_start();
    send_byte(a, tag_of(0));
    for (int k = 1; k < 8; k++) send_byte(fill ^ 8'(k * 37), tag_of(k));
    send_byte(d5, tag_of(8));
    send_byte(d6, tag_of(9));
    send_byte(d7, tag_of(10));
  endtask

  task automatic check_regs(input string tag);
    repeat (8) @(negedge clk);
    chk(out_en == ({10{oe}} & exp_en), tag, 16'(out_en), 16'({10{oe}} & exp_en));
    chk(dbg_byte == exp_dbg, tag, 16'(dbg_byte), 16'(exp_dbg));
  endtask

  initial begin
    repeat (5) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(out_en == 10'h3FF, "R1 reset enables", 16'(out_en), 16'h3FF);
    chk(dbg_byte == 8'hFF, "R1 reset dbg", 16'(dbg_byte), 16'hFF);
    chk(sda_pull == 1'b0, "R1 reset sda", 16'(sda_pull), 16'h0);

    // R5 full matched frame, MSB-first fields
    send_frame(ADDR, 8'h5A, 8'hFE, 8'h3C, 8'h11);
    i2c_stop();
    check_regs("R5 full frame");
    chk(out_en == 10'h25A, "R5 field placement", 16'(out_en), 16'h25A);

    // R2 wrong address: no acks, nothing changes
    send_frame(8'hD0, 8'h00, 8'h00, 8'h00, 8'h77);
    i2c_stop();
    check_regs("R2 mismatch unchanged");

    // R3 R4 different filler values, same kept bytes
    send_frame(ADDR, 8'h5A, 8'hFE, 8'h3C, 8'hE8);
    i2c_stop();
    check_regs("R3 R4 filler ignored");

    // R4 frame cut after data byte 4
    i2c_start();
    send_byte(ADDR, tag_of(0));
    for (int k = 1; k < 8; k++) send_byte(8'h00, tag_of(k));
    i2c_stop();
    check_regs("R4 discarded bytes no effect");

    // R7 global enable low
    oe = 0; quiet = 2;
    check_regs("R7 oe low");
    chk(out_en == 10'h000, "R7 oe low off", 16'(out_en), 16'h0);
    oe = 1; quiet = 2;

    // R6 stop after data byte 5 keeps it
    i2c_start();
    send_byte(ADDR, tag_of(0));
    for (int k = 1; k < 8; k++) send_byte(8'hC3, tag_of(k));
    send_byte(8'h0F, tag_of(8));
    i2c_stop();
    check_regs("R6 partial commit");
    chk(out_en == 10'h20F, "R6 partial value", 16'(out_en), 16'h20F);

    // R9 repeated start mid-frame, then full frame
    i2c_start();
    send_byte(ADDR, tag_of(0));
    for (int k = 1; k < 5; k++) send_byte(8'h99, tag_of(k));
    send_frame(ADDR, 8'hFF, 8'h03, 8'h81, 8'h42);
    check_regs("R9 restart frame");
    chk(out_en == 10'h3FF, "R9 restart value", 16'(out_en), 16'h3FF);

    // R8 twelfth byte: no ack, no change
    send_byte(8'h00, tag_of(11));
    i2c_stop();
    check_regs("R8 extra byte no effect");
    chk(dbg_byte == 8'h81, "R8 dbg kept", 16'(dbg_byte), 16'h81);

    finish_run();
  end
endmodule